// File: doc/BRIEF.md
# Bank-Crossing Turnaround Inserter

This block sits between an access requester and the external memory bus. It remembers where the last external access went: the address of that access and whether it targeted program or data space. When the next external access would land on a different device, the block holds the requester for one clock. That one idle cycle lets the previous device release the bus before the next device starts to drive it.

Two events count as a device change. The first is a move to another bank inside the same space. The second is a move from program space to data space. Software chooses the bank size through a small control register. The size is a power of two between 4K and 64K words. A separate control bit turns the space-change turnaround on or off.

The requester keeps its request asserted while `stall` is high. The access itself is passed straight through to the `out_*` ports in the cycle in which it is accepted.

Top module: `bank_turnaround_top`

## Requirements
- R1: While reset is asserted and after it is released, `stall` is low and `out_valid` is low whenever `req_valid` is low.
- R2: The first external access after reset is never stalled, whatever its address or space.
- R3: An external access in the same space as the stored one, but in a different bank, raises `stall` for exactly one cycle. In the next cycle the same held request is forwarded with `stall` low.
- R4: An external access in the same space and the same bank as the stored one is forwarded without a stall.
- R5: When the space-change bit `cfg_wdata[4]` is 1, an external data access (`req_space`=1) that follows an external program access (`req_space`=0) gets one stall cycle, even if both addresses fall in the same bank.
- R6: An external program access that follows an external data access is not stalled.
- R7: When the space-change bit is 0, a program-to-data change gets no stall. Bank crossings inside one space still do.
- R8: The bank-size code `cfg_wdata[3:0]` = k selects banks of 2^(k+12) words for k = 0 to 4. Any code above 4 acts as 4. Reset sets code 4 and the space-change bit to 1.
- R9: An internal access (`req_ext`=0) is never stalled and does not change the stored bank and space.
- R10: `out_valid` equals `req_valid` and not `stall`. `out_addr`, `out_space` and `out_ext` copy the request in the same cycle.
- R11: A control write with `cfg_we` high affects accesses from the next cycle on, and the configuration does not change without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | [3:0] bank-size code, [4] space-change turnaround enable |
| req_valid | input | 1 | Access request, held while stalled |
| req_ext | input | 1 | 1 = external access, 0 = internal |
| req_space | input | 1 | 0 = program space, 1 = data space |
| req_addr | input | ADDR_W | Word address of the access |
| stall | output | 1 | Hold the request this cycle |
| out_valid | output | 1 | Forwarded access is valid |
| out_ext | output | 1 | Forwarded external flag |
| out_space | output | 1 | Forwarded space |
| out_addr | output | ADDR_W | Forwarded address |

## Verification
The assertions check, on every cycle, the rules that apply in all cases:
- a stall never lasts two cycles;
- a stall always hides the forwarded access;
- internal accesses and the first access after reset never stall;
- repeating the stored address never stalls;
- a held request goes out right after its stall;
- the configuration changes only on a write.

Whether a given pair of addresses crosses a bank at each programmed size can only be shown by the bench's scenarios. The same is true for the direction of the program-to-data rule, the clamping of large size codes, and the defaults restored by reset.

// File: rtl/bta_pkg.sv
package bta_pkg;

    // space encoding on the request side
    typedef enum logic {
        SP_PROG = 1'b0,
        SP_DATA = 1'b1
    } space_e;

    // control register image
    typedef struct packed {
        logic       xsp_en;    // turnaround on program->data change
        logic [3:0] size_code; // bank = 2^(code+BASE) words
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/bta_cfg_reg.sv
module bta_cfg_reg
    import bta_pkg::*;
#(
    parameter logic [3:0] RESET_CODE = 4'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{xsp_en: 1'b1, size_code: RESET_CODE};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));

endmodule

// File: rtl/bta_bank_cmp.sv
module bta_bank_cmp
    import bta_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BASE_LOG2 = 12,
    parameter int KMAX      = 4
) (
    input  cfg_t              cfg,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_space,
    input  logic [ADDR_W-1:0] prv_addr,
    input  logic              prv_space,
    output logic              need_gap
);

    localparam int SH_W = $clog2(ADDR_W + BASE_LOG2 + KMAX + 1);

    logic [3:0]        k_eff;
    logic [SH_W-1:0]   shamt;
    logic [ADDR_W-1:0] diff;
    logic              bank_cross;
    logic              to_data;

    always_comb begin
        // codes above KMAX clamp to the largest bank
        k_eff      = (cfg.size_code > 4'(KMAX)) ? 4'(KMAX) : cfg.size_code;
        shamt      = SH_W'(BASE_LOG2) + SH_W'(k_eff);
        diff       = (cur_addr ^ prv_addr) >> shamt;
        bank_cross = (cur_space == prv_space) && (|diff);
        to_data    = cfg.xsp_en && (prv_space == SP_PROG) && (cur_space == SP_DATA);
        need_gap   = bank_cross || to_data;
    end

endmodule

// File: rtl/bank_turnaround_top.sv
module bank_turnaround_top
    import bta_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BASE_LOG2 = 12,
    parameter int KMAX      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_wdata,
    input  logic              req_valid,
    input  logic              req_ext,
    input  logic              req_space,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              stall,
    output logic              out_valid,
    output logic              out_ext,
    output logic              out_space,
    output logic [ADDR_W-1:0] out_addr
);

    typedef struct packed {
        logic              prev_valid;
        logic              prev_space;
        logic [ADDR_W-1:0] prev_addr;
        logic              gap;
    } st_t;

    st_t  st_d, st_q;
    cfg_t cfg_q;
    logic need_gap;
    logic ext_go;

    bta_cfg_reg #(
        .RESET_CODE (4'(KMAX))
    ) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    bta_bank_cmp #(
        .ADDR_W    (ADDR_W),
        .BASE_LOG2 (BASE_LOG2),
        .KMAX      (KMAX)
    ) cmp_i (
        .cfg       (cfg_q),
        .cur_addr  (req_addr),
        .cur_space (req_space),
        .prv_addr  (st_q.prev_addr),
        .prv_space (st_q.prev_space),
        .need_gap  (need_gap)
    );

    always_comb begin
        ext_go    = req_valid && req_ext;
        stall     = ext_go && st_q.prev_valid && need_gap && !st_q.gap;
        out_valid = req_valid && !stall;
        out_ext   = req_ext;
        out_space = req_space;
        out_addr  = req_addr;

        st_d     = st_q;
        st_d.gap = stall;
        if (out_valid && req_ext) begin
            st_d.prev_valid = 1'b1;
            st_d.prev_space = req_space;
            st_d.prev_addr  = req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    gap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R3
    held_goes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall ##1 (req_valid && req_ext && $stable(req_addr) && $stable(req_space))
        |-> out_valid);

    // R10
    stall_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !out_valid);

    // R9
    internal_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ext) |-> !stall);

    // R2
    first_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.prev_valid |-> !stall);

    // R4
    same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prev_valid && req_addr == st_q.prev_addr && req_space == st_q.prev_space)
        |-> !stall);

endmodule

// File: tb/bank_turnaround_top_tb_top.sv
module bank_turnaround_top_tb_top;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [4:0]    cfg_wdata;
    logic          req_valid, req_ext, req_space;
    logic [AW-1:0] req_addr;
    logic          stall, out_valid, out_ext, out_space;
    logic [AW-1:0] out_addr;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bank_turnaround_top #(.ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .req_valid (req_valid),
        .req_ext   (req_ext),
        .req_space (req_space),
        .req_addr  (req_addr),
        .stall     (stall),
        .out_valid (out_valid),
        .out_ext   (out_ext),
        .out_space (out_space),
        .out_addr  (out_addr)
    );

    typedef struct packed {
        logic          we;
        logic [4:0]    wd;
        logic          rv;
        logic          ext;
        logic          sp;
        logic [AW-1:0] addr;
        logic          stl;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 4'd1},  // R1 idle
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 20'h00100, 1'b0, 4'd2},  // R2 first access
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 20'h0F000, 1'b0, 4'd4},  // R4 same 64K bank
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 20'h10000, 1'b1, 4'd3},  // R3 crossing
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 20'h10000, 1'b0, 4'd3},  // R3 held, goes out
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h10004, 1'b1, 4'd5},  // R5 prog->data
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h10004, 1'b0, 4'd5},  // R5 held
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 20'h10008, 1'b0, 4'd6},  // R6 data->prog
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b1, 20'h30000, 1'b0, 4'd9},  // R9 internal
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 20'h1FFFF, 1'b0, 4'd9},  // R9 stored unchanged
        '{1'b1, 5'h10, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 4'd11}, // R11 write 4K, en
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 20'h1E000, 1'b1, 4'd8},  // R8 4K crossing
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 20'h1E000, 1'b0, 4'd8},  // R8 held
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 20'h1EFFF, 1'b0, 4'd8},  // R8 same 4K bank
        '{1'b1, 5'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 4'd7},  // R7 disable space
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h1E000, 1'b0, 4'd7},  // R7 prog->data free
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h1F000, 1'b1, 4'd7},  // R7 crossing kept
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h1F000, 1'b0, 4'd7},  // R7 held
        '{1'b1, 5'h19, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 4'd8},  // R8 code 9
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h2F000, 1'b1, 4'd8},  // R8 clamp to 64K
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h2F000, 1'b0, 4'd8},  // R8 held
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h20000, 1'b0, 4'd8}   // R8 same 64K bank
    };

    task automatic check(input int rq, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, got, exp);
        end
    endtask

    task automatic step(input logic we, input logic [4:0] wd, input logic rv,
                        input logic ext, input logic sp, input logic [AW-1:0] addr,
                        input logic exp_stl, input int rq);
        @(negedge clk);
        cfg_we    = we;
        cfg_wdata = wd;
        req_valid = rv;
        req_ext   = ext;
        req_space = sp;
        req_addr  = addr;
        #5;
        check(rq, "stall", 32'(stall), 32'(exp_stl));
        // R10 forwarding
        check(rq, "out_valid", 32'(out_valid), 32'(rv & ~exp_stl));
        if (rv) begin
            check(10, "out_addr", 32'(out_addr), 32'(addr));
            check(10, "out_space", 32'(out_space), 32'(sp));
            check(10, "out_ext", 32'(out_ext), 32'(ext));
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_wdata = '0;
        req_valid = 1'b0;
        req_ext   = 1'b0;
        req_space = 1'b0;
        req_addr  = '0;
        repeat (2) @(negedge clk);
        #5;
        // R1 during reset
        check(1, "stall in reset", 32'(stall), 32'd0);
        check(1, "out_valid in reset", 32'(out_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].we, VEC[i].wd, VEC[i].rv, VEC[i].ext, VEC[i].sp,
                 VEC[i].addr, VEC[i].stl, int'(VEC[i].rq));
        end

        // directed: reset mid-run restores defaults and forgets history
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b0;
        rst_n     = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h50010, 1'b0, 2);  // R2 after reset
        step(1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h5F000, 1'b0, 8);  // R8 default 64K
        step(1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 20'h5F000, 1'b0, 6);  // R6
        step(1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h5F000, 1'b1, 5);  // R5 default on
        step(1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 20'h5F000, 1'b0, 3);  // R3 single cycle
        step(1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 1);  // R1 idle

        done = 1'b1;
        summary();
        $finish;
    end

endmodule